// File: doc/BRIEF.md
# Page-Bounded Stream Prefetcher

This block sits beside a second-level cache and watches the line-granular read requests that arrive from the level above. Those requests include data loads, stores, first-level prefetches and instruction fetches, and the block treats them all the same way. The block keeps a small table of streams, one per 4 KiB page. When it sees a run of consecutive 64-byte lines in a page, it learns whether the run is rising or falling. Once that run is confirmed, it offers line prefetches that move ahead of the demand stream in the learned direction.

Each monitored lookup can produce up to two prefetch candidates. They leave through a valid/ready port in consecutive cycles. Candidates never cross the page of the triggering request, and the prefetch frontier stays at most a bounded distance (20 lines by default) ahead of the newest demand line. The monitor input has no back-pressure. Prefetches are hints, so the output port is allowed to lose candidates rather than stall the monitor.

Top module: `pfs_stream_prefetch`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `pf_valid` is low. After reset the table is empty, so the first lookup to any page offers no prefetch.
- R2: A lookup whose page is not tracked allocates an entry and offers no prefetch. A stream is confirmed on the second successive step of exactly one line in the same direction. The confirming lookup, and every further same-direction one-line step, generate prefetches.
- R3: Line addresses are byte address divided by 64. The low 6 bits are the line offset inside the page, and the upper bits are the page number. In a rising stream, candidates are base+1 and base+2, where base is the larger of the stream's prefetch pointer and the demand offset.
- R4: In a falling stream, candidates are base-1 and base-2, where base is the smaller of the prefetch pointer and the demand offset.
- R5: The first candidate of a lookup appears on `pf_line` in the cycle after the lookup, and the second appears in the cycle after that. With no new lookup and no offer pending, `pf_valid` stays low.
- R6: Every candidate keeps the page number of its lookup and has an offset between 0 and 63. Generation stops at the page edge, so a full rising or falling sweep of one page yields each of the other 61 lines exactly once.
- R7: A candidate is generated only while the distance from the demand offset to the current frontier is below 20. No offered line is more than 20 lines, or fewer than 1 line, from the latest demand offset.
- R8: A lookup that repeats the last line of its stream changes nothing. A one-line step against the stored direction restarts training in the new direction. Any larger jump clears the training. The pointer is reset to the demand offset in both of those last two cases.
- R9: Up to 8 pages are tracked at once. A new page takes the lowest-numbered free entry, or else the least recently looked-up entry, and the other entries keep their training.
- R10: While `pf_valid` is high and `pf_ready` low, the offer is held unchanged until it is taken or a new lookup replaces it. A pending second candidate is dropped if the port was not ready when it would move out. A new lookup discards any offer and pending candidate in favour of its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mon_valid | input | 1 | A monitored upper-level read request is present this cycle |
| mon_line | input | LINE_AW | Line address of the monitored request (page number above a 6-bit offset) |
| pf_ready | input | 1 | Downstream accepts the offered prefetch |
| pf_valid | output | 1 | A prefetch line is offered |
| pf_line | output | LINE_AW | Line address of the offered prefetch |

## Verification
The hardest states to reach are those where a confirmed stream presses against both limits at once. The frontier must sit exactly 20 lines ahead, so that only one candidate comes out, and the frontier must also run into the edge of the page. A confirmed stream must also survive eviction pressure from eight other pages. The stimulus sweeps whole pages upward and downward with one idle cycle between lookups, so that both candidates drain and the frontier climbs to its limit and then stops at line 63 or line 0. Separate sequences train eight pages in turn and then bring in a ninth before revisiting. A long pseudo-random mix of small steps, repeats and jumps over eleven pages, with a randomly stalling output port, is compared every cycle against a queue-based model.

// File: rtl/pfs_pkg.sv
package pfs_pkg;
  localparam int LINE_BYTES = 64;
  localparam int PAGE_BYTES = 4096;
  localparam int OFF_W = $clog2(PAGE_BYTES / LINE_BYTES);
  localparam int SW = OFF_W + 3;

  typedef struct packed {
    logic [OFF_W-1:0] last;
    logic [OFF_W-1:0] ahead_ptr;
    logic             down;
    logic [1:0]       hits;
  } strm_t;
endpackage

// File: rtl/pfs_match.sv
module pfs_match #(
  parameter int N = 8,
  parameter int PAGE_W = 20,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]             vld,
  input  logic [N-1:0][PAGE_W-1:0] pages,
  input  logic [PAGE_W-1:0]        page,
  output logic                     hit,
  output logic [IW-1:0]            idx
);
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vld[i] && pages[i] == page) begin
        hit = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pfs_lru.sv
module pfs_lru #(
  parameter int N = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          touch,
  input  logic [IW-1:0] touch_idx,
  input  logic [N-1:0]  vld,
  output logic [IW-1:0] victim
);
  logic [N-1:0][IW-1:0] age;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) age[i] <= IW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++) begin
        if (IW'(i) == touch_idx) age[i] <= '0;
        else if (age[i] < age[touch_idx]) age[i] <= age[i] + IW'(1);
      end
    end
  end

  always_comb begin
    victim = '0;
    for (int i = 0; i < N; i++)
      if (age[i] == IW'(N - 1)) victim = IW'(i);
    for (int i = N - 1; i >= 0; i--)
      if (!vld[i]) victim = IW'(i);
  end
endmodule

// File: rtl/pfs_step.sv
module pfs_step
  import pfs_pkg::*;
#(
  parameter int RUN_AHEAD = 20
) (
  input  logic             hit,
  input  strm_t            cur,
  input  logic [OFF_W-1:0] off,
  output strm_t            nxt,
  output logic             c1_v,
  output logic             c2_v,
  output logic [OFF_W-1:0] c1_off,
  output logic [OFF_W-1:0] c2_off
);
  localparam logic signed [SW-1:0] LIM   = SW'(RUN_AHEAD);
  localparam logic signed [SW-1:0] PGMAX = SW'((1 << OFF_W) - 1);
  localparam logic signed [SW-1:0] ONE   = SW'(1);

  logic signed [SW-1:0] off_s, last_s, ptr_s, delta, step, ahd, base, d0, c1, c2;

  assign off_s  = {{(SW-OFF_W){1'b0}}, off};
  assign last_s = {{(SW-OFF_W){1'b0}}, cur.last};
  assign ptr_s  = {{(SW-OFF_W){1'b0}}, cur.ahead_ptr};
  assign delta  = off_s - last_s;
  assign c1_off = c1[OFF_W-1:0];
  assign c2_off = c2[OFF_W-1:0];

  always_comb begin
    nxt  = cur;
    c1_v = 1'b0;
    c2_v = 1'b0;
    step = ONE;
    ahd  = '0;
    base = off_s;
    d0   = '0;
    c1   = off_s;
    c2   = off_s;
    if (!hit) begin
      nxt.last      = off;
      nxt.ahead_ptr = off;
      nxt.down      = 1'b0;
      nxt.hits      = 2'd0;
    end else if (delta == ONE || delta == -ONE) begin
      nxt.last = off;
      nxt.down = delta[SW-1];
      if (cur.hits != 2'd0 && cur.down == delta[SW-1]) begin
        nxt.hits = (cur.hits == 2'd2) ? 2'd2 : cur.hits + 2'd1;
      end else begin
        nxt.hits      = 2'd1;
        nxt.ahead_ptr = off;
      end
      if (nxt.hits == 2'd2) begin
        step = nxt.down ? -ONE : ONE;
        ahd  = nxt.down ? off_s - ptr_s : ptr_s - off_s;
        base = ahd[SW-1] ? off_s : ptr_s;
        d0   = ahd[SW-1] ? '0 : ahd;
        c1   = base + step;
        c2   = base + step + step;
        c1_v = (d0 < LIM) && !c1[SW-1] && (c1 <= PGMAX);
        c2_v = c1_v && (d0 + ONE < LIM) && !c2[SW-1] && (c2 <= PGMAX);
        nxt.ahead_ptr = c2_v ? c2[OFF_W-1:0] : (c1_v ? c1[OFF_W-1:0] : base[OFF_W-1:0]);
      end
    end else if (delta != '0) begin
      nxt.last      = off;
      nxt.ahead_ptr = off;
      nxt.hits      = 2'd0;
    end
  end
endmodule

// File: rtl/pfs_stream_prefetch.sv
module pfs_stream_prefetch
  import pfs_pkg::*;
#(
  parameter int LINE_AW   = 26,
  parameter int NSTREAM   = 8,
  parameter int RUN_AHEAD = 20
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               mon_valid,
  input  logic [LINE_AW-1:0] mon_line,
  input  logic               pf_ready,
  output logic               pf_valid,
  output logic [LINE_AW-1:0] pf_line
);
  localparam int PAGE_W = LINE_AW - OFF_W;
  localparam int IW = $clog2(NSTREAM);

  logic [PAGE_W-1:0] req_page;
  logic [OFF_W-1:0]  req_off;
  assign req_page = mon_line[LINE_AW-1:OFF_W];
  assign req_off  = mon_line[OFF_W-1:0];

  logic [NSTREAM-1:0]             vld;
  logic [NSTREAM-1:0][PAGE_W-1:0] pages;
  strm_t                          tbl [NSTREAM];

  logic          hit;
  logic [IW-1:0] hit_idx, victim, sel;
  strm_t         nxt;
  logic          c1_v, c2_v;
  logic [OFF_W-1:0] c1_off, c2_off;

  pfs_match #(.N(NSTREAM), .PAGE_W(PAGE_W)) u_match (
    .vld(vld), .pages(pages), .page(req_page), .hit(hit), .idx(hit_idx)
  );

  pfs_lru #(.N(NSTREAM)) u_lru (
    .clk(clk), .rst(rst), .touch(mon_valid), .touch_idx(sel), .vld(vld), .victim(victim)
  );

  assign sel = hit ? hit_idx : victim;

  pfs_step #(.RUN_AHEAD(RUN_AHEAD)) u_step (
    .hit(hit), .cur(tbl[sel]), .off(req_off), .nxt(nxt),
    .c1_v(c1_v), .c2_v(c2_v), .c1_off(c1_off), .c2_off(c2_off)
  );

  always_ff @(posedge clk) begin
    if (rst) vld <= '0;
    else if (mon_valid) vld[sel] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (mon_valid) begin
      pages[sel] <= req_page;
      tbl[sel]   <= nxt;
    end
  end

  logic               pend_v;
  logic [LINE_AW-1:0] pend_l;

  always_ff @(posedge clk) begin
    if (rst) begin
      pf_valid <= 1'b0;
      pf_line  <= '0;
      pend_v   <= 1'b0;
      pend_l   <= '0;
    end else if (mon_valid) begin
      pf_valid <= c1_v;
      pf_line  <= {req_page, c1_off};
      pend_v   <= c2_v;
      pend_l   <= {req_page, c2_off};
    end else if (pf_valid && !pf_ready) begin
      pend_v <= 1'b0;
    end else begin
      pf_valid <= pend_v;
      pf_line  <= pend_l;
      pend_v   <= 1'b0;
    end
  end
endmodule

// File: rtl/pfs_chk.sv
module pfs_chk
  import pfs_pkg::*;
#(
  parameter int LINE_AW   = 26,
  parameter int RUN_AHEAD = 20
) (
  input logic               clk,
  input logic               rst,
  input logic               mon_valid,
  input logic [LINE_AW-1:0] mon_line,
  input logic               pf_ready,
  input logic               pf_valid,
  input logic [LINE_AW-1:0] pf_line
);
  logic [LINE_AW-1:0] seen;
  logic               seen_v;
  logic [OFF_W:0]     gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_v <= 1'b0;
      seen   <= '0;
    end else if (mon_valid) begin
      seen_v <= 1'b1;
      seen   <= mon_line;
    end
  end

  always_comb begin
    if (pf_line[OFF_W-1:0] > seen[OFF_W-1:0])
      gap = {1'b0, pf_line[OFF_W-1:0]} - {1'b0, seen[OFF_W-1:0]};
    else
      gap = {1'b0, seen[OFF_W-1:0]} - {1'b0, pf_line[OFF_W-1:0]};
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !pf_valid);

  // R6
  same_page_chk: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (seen_v && pf_line[LINE_AW-1:OFF_W] == seen[LINE_AW-1:OFF_W]));

  // R7
  run_ahead_chk: assert property (@(posedge clk) disable iff (rst)
    pf_valid |-> (gap != '0 && int'(gap) <= RUN_AHEAD));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (pf_valid && !pf_ready && !mon_valid) |=> (pf_valid && $stable(pf_line)));

  // R5
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!mon_valid && !pf_valid) |=> !pf_valid);
endmodule

bind pfs_stream_prefetch pfs_chk #(.LINE_AW(LINE_AW), .RUN_AHEAD(RUN_AHEAD)) u_pfs_chk (
  .clk(clk), .rst(rst), .mon_valid(mon_valid), .mon_line(mon_line),
  .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_line(pf_line)
);

// File: tb/tb_pfs_stream_prefetch.sv
module tb_pfs_stream_prefetch;
  localparam int LAW = 26;
  localparam int NS  = 8;
  localparam int RA  = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mon_valid = 1'b0;
  logic pf_ready = 1'b1;
  logic [LAW-1:0] mon_line = '0;
  logic pf_valid;
  logic [LAW-1:0] pf_line;

  always #4 clk = ~clk;

  pfs_stream_prefetch #(.LINE_AW(LAW), .NSTREAM(NS), .RUN_AHEAD(RA)) dut (
    .clk(clk), .rst(rst), .mon_valid(mon_valid), .mon_line(mon_line),
    .pf_ready(pf_ready), .pf_valid(pf_valid), .pf_line(pf_line)
  );

  int total = 0, bad = 0;
  string cur_req = "R1";
  bit running = 0, done = 0, rmode = 0;

  // behavioural reference state
  int m_vld[NS], m_pg[NS], m_last[NS], m_ptr[NS], m_down[NS], m_hits[NS];
  int lru[$];
  bit ev = 0, pv = 0;
  int el = 0, pl = 0, lk_off = 0;

  // phase statistics
  int acc_cnt, acc_max, acc_min, max_ahead;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (rst) begin
      ev = 0; pv = 0;
      for (int i = 0; i < NS; i++) m_vld[i] = 0;
      lru.delete();
      for (int i = 0; i < NS; i++) lru.push_back(i);
    end else if (mon_valid) begin
      int page, off, h, idx, d, s, ahd, base, d0;
      bit c1v, c2v;
      int c1o, c2o;
      page = int'(mon_line) / 64;
      off  = int'(mon_line) % 64;
      lk_off = off;
      c1v = 0; c2v = 0; c1o = 0; c2o = 0;
      h = -1;
      for (int i = 0; i < NS; i++) if (m_vld[i] == 1 && m_pg[i] == page) h = i;
      if (h < 0) begin
        idx = -1;
        for (int i = NS - 1; i >= 0; i--) if (m_vld[i] == 0) idx = i;
        if (idx < 0) idx = lru[$];
        m_vld[idx] = 1; m_pg[idx] = page; m_last[idx] = off; m_ptr[idx] = off;
        m_down[idx] = 0; m_hits[idx] = 0;
      end else begin
        idx = h;
        d = off - m_last[idx];
        if (d == 1 || d == -1) begin
          if (m_hits[idx] > 0 && m_down[idx] == (d < 0 ? 1 : 0))
            m_hits[idx] = (m_hits[idx] >= 2) ? 2 : m_hits[idx] + 1;
          else begin
            m_hits[idx] = 1; m_ptr[idx] = off;
          end
          m_down[idx] = (d < 0) ? 1 : 0;
          m_last[idx] = off;
          if (m_hits[idx] == 2) begin
            s = m_down[idx] ? -1 : 1;
            ahd = (m_ptr[idx] - off) * s;
            base = (ahd < 0) ? off : m_ptr[idx];
            d0 = (base - off) * s;
            if (d0 < RA && base + s >= 0 && base + s <= 63) begin
              c1v = 1; c1o = base + s;
              if (d0 + 1 < RA && base + 2*s >= 0 && base + 2*s <= 63) begin
                c2v = 1; c2o = base + 2*s;
              end
            end
            m_ptr[idx] = c2v ? c2o : (c1v ? c1o : base);
          end
        end else if (d != 0) begin
          m_hits[idx] = 0; m_last[idx] = off; m_ptr[idx] = off;
        end
      end
      for (int k = 0; k < lru.size(); k++)
        if (lru[k] == idx) begin lru.delete(k); break; end
      lru.push_front(idx);
      ev = c1v; el = page * 64 + c1o;
      pv = c2v; pl = page * 64 + c2o;
    end else if (ev && !pf_ready) begin
      pv = 0;
    end else begin
      ev = pv; el = pl; pv = 0;
    end
  end

  // every-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (running && !rst) begin
      chk(pf_valid == ev, cur_req, "pf_valid vs model", int'(pf_valid), int'(ev));
      if (ev) chk(int'(pf_line) == el, cur_req, "pf_line vs model", int'(pf_line), el);
      if (pf_valid && pf_ready) begin
        int o, a;
        o = int'(pf_line) % 64;
        a = (o > lk_off) ? o - lk_off : lk_off - o;
        acc_cnt++;
        if (o > acc_max) acc_max = o;
        if (o < acc_min) acc_min = o;
        if (a > max_ahead) max_ahead = a;
      end
    end
  end

  task automatic clr_stats();
    acc_cnt = 0; acc_max = -1; acc_min = 64; max_ahead = 0;
  endtask

  task automatic look(int page, int off);
    @(posedge clk); #1;
    mon_valid = 1'b1;
    mon_line = LAW'(page * 64 + off);
    if (rmode) pf_ready = 1'($urandom_range(0, 1));
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(posedge clk); #1;
      mon_valid = 1'b0;
      if (rmode) pf_ready = 1'($urandom_range(0, 1));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "run did not finish", 0, 1);
    finish_run();
  end

  initial begin
    int cursor[11];
    clr_stats();
    repeat (3) @(negedge clk);
    chk(pf_valid == 1'b0, "R1", "pf_valid in reset", int'(pf_valid), 0);
    @(posedge clk); #1; rst = 1'b0;
    running = 1;
    @(negedge clk);
    chk(pf_valid == 1'b0, "R1", "pf_valid after reset", int'(pf_valid), 0);

    // R2: training then confirmation on page 9
    cur_req = "R2";
    look(9, 10); idle(2);
    chk(pf_valid == 1'b0, "R2", "no prefetch on allocation", int'(pf_valid), 0);
    look(9, 11); idle(2);
    chk(pf_valid == 1'b0, "R2", "no prefetch after one step", int'(pf_valid), 0);
    look(9, 12); idle(1);
    @(negedge clk);
    chk(int'(pf_line) == 9*64 + 13 && pf_valid, "R2", "first candidate", int'(pf_line), 9*64 + 13);
    @(negedge clk);
    chk(int'(pf_line) == 9*64 + 14 && pf_valid, "R5", "second candidate next cycle", int'(pf_line), 9*64 + 14);
    idle(2);

    // R3/R6/R7: full rising sweep of page 5
    cur_req = "R3"; clr_stats();
    for (int o = 0; o < 64; o++) begin look(5, o); idle(1); end
    idle(3);
    chk(acc_cnt == 61, "R6", "rising sweep line count", acc_cnt, 61);
    chk(acc_max == 63, "R6", "rising sweep top line", acc_max, 63);
    chk(max_ahead == RA, "R7", "largest run-ahead", max_ahead, RA);

    // R4/R6: full falling sweep of page 6
    cur_req = "R4"; clr_stats();
    for (int o = 63; o >= 0; o--) begin look(6, o); idle(1); end
    idle(3);
    chk(acc_cnt == 61, "R6", "falling sweep line count", acc_cnt, 61);
    chk(acc_min == 0, "R4", "falling sweep bottom line", acc_min, 0);

    // R5: back-to-back lookups overwrite the second candidate
    cur_req = "R5"; clr_stats();
    for (int o = 0; o < 30; o++) look(7, o);
    idle(3);
    chk(acc_cnt == 28, "R5", "one candidate per back-to-back lookup", acc_cnt, 28);

    // R10: stall holds first, drops second
    cur_req = "R10";
    pf_ready = 1'b0;
    look(10, 0); idle(1); look(10, 1); idle(1); look(10, 2); idle(4);
    chk(pf_valid && int'(pf_line) == 10*64 + 3, "R10", "held offer", int'(pf_line), 10*64 + 3);
    pf_ready = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(pf_valid == 1'b0, "R10", "second dropped after stall", int'(pf_valid), 0);
    idle(2);

    // R8: repeat, reversal and jump
    cur_req = "R8";
    look(11, 10); idle(1); look(11, 11); idle(1); look(11, 12); idle(3);
    look(11, 12); idle(3);
    chk(pf_valid == 1'b0, "R8", "repeat gives nothing", int'(pf_valid), 0);
    look(11, 13); idle(1); @(negedge clk);
    chk(int'(pf_line) == 11*64 + 15, "R8", "repeat kept pointer", int'(pf_line), 11*64 + 15);
    idle(2);
    look(11, 12); idle(3);
    chk(pf_valid == 1'b0, "R8", "reversal retrains", int'(pf_valid), 0);
    look(11, 11); idle(1); @(negedge clk);
    chk(int'(pf_line) == 11*64 + 10, "R8", "reversed stream confirmed", int'(pf_line), 11*64 + 10);
    idle(2);
    look(11, 30); idle(2); look(11, 31); idle(3);
    chk(pf_valid == 1'b0, "R8", "jump clears confirmation", int'(pf_valid), 0);
    look(11, 32); idle(1); @(negedge clk);
    chk(int'(pf_line) == 11*64 + 33, "R8", "retrained after jump", int'(pf_line), 11*64 + 33);
    idle(2);

    // R9: eight trained pages, then a ninth evicts the oldest
    cur_req = "R9";
    for (int p = 20; p < 28; p++) begin look(p, 5); idle(1); look(p, 6); idle(1); end
    look(28, 5); idle(3);
    look(21, 7); idle(1); @(negedge clk);
    chk(pf_valid && int'(pf_line) == 21*64 + 8, "R9", "surviving page kept training", int'(pf_line), 21*64 + 8);
    idle(2);
    look(20, 7); idle(3);
    chk(pf_valid == 1'b0, "R9", "evicted page restarts", int'(pf_valid), 0);

    // mixed pseudo-random traffic with a stalling port
    cur_req = "R2"; rmode = 1;
    for (int i = 0; i < 11; i++) cursor[i] = 32;
    for (int n = 0; n < 3000; n++) begin
      int pg, r;
      pg = $urandom_range(0, 10);
      r = $urandom_range(0, 9);
      if (r < 4) cursor[pg] = cursor[pg] + 1;
      else if (r < 7) cursor[pg] = cursor[pg] - 1;
      else if (r == 9) cursor[pg] = $urandom_range(0, 63);
      if (cursor[pg] < 0 || cursor[pg] > 63) cursor[pg] = $urandom_range(0, 63);
      look(30 + pg, cursor[pg]);
      idle($urandom_range(0, 2));
    end
    rmode = 0; pf_ready = 1'b1;
    idle(4);
    finish_run();
  end
endmodule